// File: doc/BRIEF.md
# Boundary-Scan Test Access Port for a Synchronous Memory

This block is the test access port that sits beside a synchronous memory die. A tester drives the four serial pins (clock, mode select, data in, optional reset) and the block walks the standard sixteen-state test controller. A three-bit instruction picks which serial path sits between data-in and data-out. The choices are a one-bit bypass stage, a fixed 32-bit identity word, or a 71-cell boundary chain that captures a parallel snapshot of the memory's I/O ring.

Two of the instructions that pick the boundary chain also raise a force-high-impedance signal for the memory's output drivers. The others leave the memory alone. Unused instruction codes fall back to the bypass stage, so the serial output always has a defined length. The boundary chain presents a parallel update register and two strobes, which mark the capture and update points for the pad cells around it.

Top module: `jtag_mem_tap`

## Requirements
- R1: The controller moves between the sixteen standard states on the rising edge of `tck` according to `tms`. Five rising edges with `tms` high reach Test-Logic-Reset from any state. `trst_n` low at a rising edge also forces Test-Logic-Reset.
- R2: Codes 3'b000 and 3'b010 put the 71-bit boundary chain in the serial path, load `io_snapshot` into it at Capture-DR, and hold `mem_hiz` high. Code 3'b100 does the same without raising `mem_hiz`.
- R3: Code 3'b001 puts the 32-bit identity register in the serial path. Code 3'b111 and the unused codes 3'b011, 3'b101 and 3'b110 put the 1-bit bypass stage in the path. None of these codes raises `mem_hiz`.
- R4: The identity word is 32'h0BA26069. Its fields are: bits 31:29 = 000, bits 28:24 = 01011, bits 23:18 = 101000, bits 17:12 = 100110, bits 11:1 = 00000110100, and bit 0 = 1.
- R5: Capture-IR loads 3'b001 into the instruction shifter. The instruction shifts least significant bit first. A new instruction takes effect only on the falling `tck` edge in Update-IR.
- R6: Entering Test-Logic-Reset, through `tms` or through `trst_n`, sets the instruction to the identity code (3'b001) and drops `mem_hiz`.
- R7: `tdo` changes only on the falling edge of `tck` and carries the least significant bit of the selected shifter first. `tdo_en` is high only while the controller is in Shift-DR or Shift-IR.
- R8: In Capture-DR the bypass stage loads 0, and the identity register reloads its fixed word.
- R9: `bsr_out` takes the boundary chain's contents on the falling edge in Update-DR, and only when the boundary chain is selected. `bsc_capture` is high in Capture-DR and `bsc_update` is high in Update-DR, each only when the boundary chain is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, sampled on `tck` |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| io_snapshot | input | 71 | Parallel view of the memory I/O ring |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_en | output | 1 | Output enable for the `tdo` pad driver |
| mem_hiz | output | 1 | Forces the memory output drivers to high impedance |
| bsc_capture | output | 1 | Boundary cell capture strobe |
| bsc_update | output | 1 | Boundary cell update strobe |
| bsr_out | output | 71 | Boundary chain update register |

## Verification
The assertions take `tms`, `tdi` and `trst_n` to be stable around each rising `tck` edge. They also take `trst_n` to be held low from time zero until the controller has seen at least one edge. The bench changes every input shortly after a falling edge and starts with `trst_n` low for several cycles. Every instruction code, including the unused ones, is loaded through a real IR scan. Each data path is then shifted for its own length plus eight extra bits, so that both the captured value and the path length are exposed at `tdo`.

// File: rtl/jtag_tap_pkg.sv
// Package: shared controller state encoding, instruction codes and
// data-path select values for the memory test access port.
package jtag_tap_pkg;

    localparam int IR_W = 3;

    // Controller states, standard four-bit encoding.
    typedef enum logic [3:0] {
        ST_EX2DR = 4'h0,
        ST_EX1DR = 4'h1,
        ST_SHDR  = 4'h2,
        ST_PSDR  = 4'h3,
        ST_SELIR = 4'h4,
        ST_UPDR  = 4'h5,
        ST_CAPDR = 4'h6,
        ST_SELDR = 4'h7,
        ST_EX2IR = 4'h8,
        ST_EX1IR = 4'h9,
        ST_SHIR  = 4'hA,
        ST_PSIR  = 4'hB,
        ST_RTI   = 4'hC,
        ST_UPIR  = 4'hD,
        ST_CAPIR = 4'hE,
        ST_TLR   = 4'hF
    } tap_state_t;

    // Instruction codes with a defined meaning.
    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
    localparam logic [IR_W-1:0] OP_PRELOAD = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;

    // Pattern loaded into the instruction shifter in Capture-IR.
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    // Which data shifter sits between tdi and tdo.
    typedef enum logic [1:0] {
        SEL_BYP = 2'd0,
        SEL_ID  = 2'd1,
        SEL_BSR = 2'd2
    } dr_sel_t;

endpackage

// File: rtl/jtag_tap_fsm.sv
// Module: sixteen-state test controller.
// Assumes tms is stable around rising tck. trst_n is a synchronous
// active-low reset that forces Test-Logic-Reset.
module jtag_tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state
);

    tap_state_t nxt;

    // Next-state table for the controller.
    always_comb begin
        unique case (state)
            ST_TLR:   nxt = tms ? ST_TLR   : ST_RTI;
            ST_RTI:   nxt = tms ? ST_SELDR : ST_RTI;
            ST_SELDR: nxt = tms ? ST_SELIR : ST_CAPDR;
            ST_CAPDR: nxt = tms ? ST_EX1DR : ST_SHDR;
            ST_SHDR:  nxt = tms ? ST_EX1DR : ST_SHDR;
            ST_EX1DR: nxt = tms ? ST_UPDR  : ST_PSDR;
            ST_PSDR:  nxt = tms ? ST_EX2DR : ST_PSDR;
            ST_EX2DR: nxt = tms ? ST_UPDR  : ST_SHDR;
            ST_UPDR:  nxt = tms ? ST_SELDR : ST_RTI;
            ST_SELIR: nxt = tms ? ST_TLR   : ST_CAPIR;
            ST_CAPIR: nxt = tms ? ST_EX1IR : ST_SHIR;
            ST_SHIR:  nxt = tms ? ST_EX1IR : ST_SHIR;
            ST_EX1IR: nxt = tms ? ST_UPIR  : ST_PSIR;
            ST_PSIR:  nxt = tms ? ST_EX2IR : ST_PSIR;
            ST_EX2IR: nxt = tms ? ST_UPIR  : ST_SHIR;
            ST_UPIR:  nxt = tms ? ST_SELDR : ST_RTI;
            default:  nxt = ST_TLR;
        endcase
    end

    // State register, updated on rising tck.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_TLR;
        else         state <= nxt;
    end

    // R1: five rising edges with tms high always end in Test-Logic-Reset.
    p_five_tms_reset_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (state == ST_TLR));

endmodule

// File: rtl/jtag_tap_ir.sv
// Module: instruction shifter, instruction hold register and decoder.
// Assumes the controller state comes from jtag_tap_fsm. The hold
// register changes on falling tck only, in Update-IR or Test-Logic-Reset.
module jtag_tap_ir
    import jtag_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_t      state,
    input  logic            tdi,
    output logic            ir_so,
    output logic [IR_W-1:0] ir_code,
    output dr_sel_t         dr_sel,
    output logic            mem_hiz
);

    logic [IR_W-1:0] ir_sh;

    // Instruction shifter: capture the fixed pattern, then shift in LSB first.
    always_ff @(posedge tck) begin
        if (!trst_n)                ir_sh <= IR_CAPTURE;
        else if (state == ST_CAPIR) ir_sh <= IR_CAPTURE;
        else if (state == ST_SHIR)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    // Instruction hold register: reset to the identity code, load on Update-IR.
    always_ff @(negedge tck) begin
        if (!trst_n || state == ST_TLR) ir_code <= OP_IDCODE;
        else if (state == ST_UPIR)      ir_code <= ir_sh;
    end

    // Decoder: path select and output float; every other code means bypass.
    always_comb begin
        unique case (ir_code)
            OP_EXTEST, OP_SAMPLEZ: begin dr_sel = SEL_BSR; mem_hiz = 1'b1; end
            OP_PRELOAD:            begin dr_sel = SEL_BSR; mem_hiz = 1'b0; end
            OP_IDCODE:             begin dr_sel = SEL_ID;  mem_hiz = 1'b0; end
            default:               begin dr_sel = SEL_BYP; mem_hiz = 1'b0; end
        endcase
    end

    assign ir_so = ir_sh[0];

    // R5: the instruction only moves on Update-IR (or Test-Logic-Reset).
    p_ir_update_only_r5: assert property (@(negedge tck) disable iff (!trst_n)
        (state != ST_UPIR && state != ST_TLR) |=> $stable(ir_code));

    // R6: Test-Logic-Reset leaves the identity instruction in place.
    p_tlr_idcode_r6: assert property (@(negedge tck) disable iff (!trst_n)
        (state == ST_TLR) |=> (ir_code == OP_IDCODE));

    // R2: outputs are only floated while the boundary chain is selected.
    p_hiz_needs_bsr_r2: assert property (@(posedge tck) disable iff (!trst_n)
        mem_hiz |-> (dr_sel == SEL_BSR));

endmodule

// File: rtl/jtag_tap_dr.sv
// Module: data shifters (bypass, identity, boundary chain) and the
// boundary update register. Assumes dr_sel only changes on falling tck.
module jtag_tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int          BSR_W   = 71,
    parameter int          ID_W    = 32,
    parameter logic [ID_W-1:0] ID_WORD = 32'h0BA2_6069
) (
    input  logic             tck,
    input  logic             trst_n,
    input  tap_state_t       state,
    input  dr_sel_t          dr_sel,
    input  logic             tdi,
    input  logic [BSR_W-1:0] io_snapshot,
    output logic             dr_so,
    output logic [BSR_W-1:0] bsr_out
);

    logic             byp_sh;
    logic [ID_W-1:0]  id_sh;
    logic [BSR_W-1:0] bsr_sh;

    logic cap_en, sh_en;
    assign cap_en = (state == ST_CAPDR);
    assign sh_en  = (state == ST_SHDR);

    // Bypass stage: capture zero, shift one bit.
    always_ff @(posedge tck) begin
        if (!trst_n)                        byp_sh <= 1'b0;
        else if (cap_en && dr_sel == SEL_BYP) byp_sh <= 1'b0;
        else if (sh_en && dr_sel == SEL_BYP)  byp_sh <= tdi;
    end

    // Identity shifter: reload the fixed word, shift LSB first.
    always_ff @(posedge tck) begin
        if (!trst_n)                         id_sh <= ID_WORD;
        else if (cap_en && dr_sel == SEL_ID) id_sh <= ID_WORD;
        else if (sh_en && dr_sel == SEL_ID)  id_sh <= {tdi, id_sh[ID_W-1:1]};
    end

    // Boundary chain: snapshot the I/O ring, shift LSB first.
    always_ff @(posedge tck) begin
        if (!trst_n)                          bsr_sh <= '0;
        else if (cap_en && dr_sel == SEL_BSR) bsr_sh <= io_snapshot;
        else if (sh_en && dr_sel == SEL_BSR)  bsr_sh <= {tdi, bsr_sh[BSR_W-1:1]};
    end

    // Boundary update register, loaded on falling tck in Update-DR.
    always_ff @(negedge tck) begin
        if (!trst_n)                                       bsr_out <= '0;
        else if (state == ST_UPDR && dr_sel == SEL_BSR)    bsr_out <= bsr_sh;
    end

    // Serial output of the selected shifter.
    always_comb begin
        unique case (dr_sel)
            SEL_ID:  dr_so = id_sh[0];
            SEL_BSR: dr_so = bsr_sh[0];
            default: dr_so = byp_sh;
        endcase
    end

    // R8: bypass captures zero.
    p_byp_capture_r8: assert property (@(posedge tck) disable iff (!trst_n)
        (cap_en && dr_sel == SEL_BYP) |=> (byp_sh == 1'b0));

    // R8: identity word is reloaded in Capture-DR.
    p_id_capture_r8: assert property (@(posedge tck) disable iff (!trst_n)
        (cap_en && dr_sel == SEL_ID) |=> (id_sh == ID_WORD));

    // R9: the update register holds outside a boundary Update-DR.
    p_bsr_hold_r9: assert property (@(negedge tck) disable iff (!trst_n)
        !(state == ST_UPDR && dr_sel == SEL_BSR) |=> $stable(bsr_out));

endmodule

// File: rtl/jtag_mem_tap.sv
// Module: top of the memory test access port. Ties together the
// controller, instruction logic and data shifters, and retimes tdo
// to falling tck. Assumes trst_n is low from power-up for a few tck.
module jtag_mem_tap
    import jtag_tap_pkg::*;
#(
    parameter int          BSR_W   = 71,
    parameter logic [31:0] ID_WORD = 32'h0BA2_6069
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [BSR_W-1:0] io_snapshot,
    output logic             tdo,
    output logic             tdo_en,
    output logic             mem_hiz,
    output logic             bsc_capture,
    output logic             bsc_update,
    output logic [BSR_W-1:0] bsr_out
);

    localparam int ID_W = $bits(ID_WORD);

    tap_state_t      state;
    dr_sel_t         dr_sel;
    logic [IR_W-1:0] ir_code;
    logic            ir_so, dr_so;

    jtag_tap_fsm i_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    jtag_tap_ir i_ir (
        .tck     (tck),
        .trst_n  (trst_n),
        .state   (state),
        .tdi     (tdi),
        .ir_so   (ir_so),
        .ir_code (ir_code),
        .dr_sel  (dr_sel),
        .mem_hiz (mem_hiz)
    );

    jtag_tap_dr #(
        .BSR_W   (BSR_W),
        .ID_W    (ID_W),
        .ID_WORD (ID_WORD)
    ) i_dr (
        .tck         (tck),
        .trst_n      (trst_n),
        .state       (state),
        .dr_sel      (dr_sel),
        .tdi         (tdi),
        .io_snapshot (io_snapshot),
        .dr_so       (dr_so),
        .bsr_out     (bsr_out)
    );

    // Boundary cell strobes, qualified by the selected path.
    assign bsc_capture = (state == ST_CAPDR) && (dr_sel == SEL_BSR);
    assign bsc_update  = (state == ST_UPDR)  && (dr_sel == SEL_BSR);

    // Serial output and its enable, retimed to falling tck.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= (state == ST_SHIR) ? ir_so : dr_so;
            tdo_en <= (state == ST_SHIR) || (state == ST_SHDR);
        end
    end

    // R7: the pad driver is only enabled from a shift state.
    p_tdo_en_shift_r7: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state == ST_SHIR || state == ST_SHDR));

    // R6: the identity instruction is active, so nothing is floated.
    p_no_hiz_idcode_r6: assert property (@(posedge tck) disable iff (!trst_n)
        (ir_code == OP_IDCODE) |-> !mem_hiz);

endmodule

// File: tb/test_jtag_mem_tap.sv
// Bench: walks every instruction code, scans each data path past its
// length and checks values against arithmetic expectations.
module test_jtag_mem_tap;

    localparam int          BSR_W   = 71;
    localparam logic [31:0] ID_WORD = 32'h0BA2_6069;

    logic             tck = 1'b0;
    logic             trst_n = 1'b0;
    logic             tms = 1'b1;
    logic             tdi = 1'b0;
    logic [BSR_W-1:0] io_snapshot = '0;
    logic             tdo, tdo_en, mem_hiz, bsc_capture, bsc_update;
    logic [BSR_W-1:0] bsr_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    jtag_mem_tap #(.BSR_W(BSR_W), .ID_WORD(ID_WORD)) i_jtag_mem_tap (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .io_snapshot(io_snapshot), .tdo(tdo), .tdo_en(tdo_en),
        .mem_hiz(mem_hiz), .bsc_capture(bsc_capture),
        .bsc_update(bsc_update), .bsr_out(bsr_out)
    );

    always #10 tck = ~tck;   // 50 MHz

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One tck: drive inputs, let the rising and falling edges pass, sample.
    task automatic tick(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #2;
    endtask

    function automatic logic pat(input int i, input int seed);
        return ((i * 5 + seed) % 7) < 3;
    endfunction

    // From Run-Test-Idle: load an instruction, return the captured IR bits.
    task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 3; i++) begin
            cap[i] = tdo;
            tick(i == 2, code[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    // From Run-Test-Idle: scan L+8 bits, count mismatches on tdo and strobes.
    task automatic scan_dr(input int len, input logic [BSR_W-1:0] cap,
                           input logic is_bsr, input int seed, output int bad);
        logic exp;
        bad = 0;
        tick(1, 0); tick(0, 0);
        if (bsc_capture !== is_bsr) bad++;
        tick(0, 0);
        for (int i = 0; i < len + 8; i++) begin
            exp = (i < len) ? cap[i] : pat(i - len, seed);
            if (tdo !== exp || tdo_en !== 1'b1) bad++;
            tick(i == len + 7, pat(i, seed));
        end
        if (tdo_en !== 1'b0) bad++;
        tick(1, 0);
        if (bsc_update !== is_bsr) bad++;
        tick(0, 0);
    endtask

    initial begin
        logic [2:0]       irc;
        logic [BSR_W-1:0] prev, exp_upd, capv;
        int               bad, len;
        logic             bsr_sel, hiz_exp;

        // Reset: hold trst_n low with tms high.
        repeat (3) tick(1, 0);
        trst_n = 1'b1;
        tick(0, 0);
        check("R6 reset mem_hiz", mem_hiz, 0);
        check("R7 reset tdo_en", tdo_en, 0);
        check("R9 reset bsr_out", bsr_out, 0);

        // Default instruction is the identity code; word value R4.
        scan_dr(32, {{(BSR_W-32){1'b0}}, ID_WORD}, 1'b0, 3, bad);
        check("R4 identity word after reset", bad, 0);

        // Sweep every code, R2 R3 R5 R7 R8 R9.
        for (int c = 0; c < 8; c++) begin
            io_snapshot = {c[2:0], 68'hA_5C3E_9172_B0D4_6E8F ^ {17{c[2:0], 1'b1}}};
            load_ir(c[2:0], irc);
            check("R5 capture-IR pattern", irc, 3'b001);
            bsr_sel = (c == 0 || c == 2 || c == 4);
            hiz_exp = (c == 0 || c == 2);
            check(hiz_exp ? "R2 mem_hiz raised" : "R3 mem_hiz low", mem_hiz, hiz_exp);
            len  = bsr_sel ? BSR_W : (c == 1 ? 32 : 1);
            capv = bsr_sel ? io_snapshot : (c == 1 ? {{(BSR_W-32){1'b0}}, ID_WORD} : '0);
            prev = bsr_out;
            scan_dr(len, capv, bsr_sel, c + 1, bad);
            check(bsr_sel ? "R2 boundary path" : (c == 1 ? "R8 identity path" : "R3 R8 bypass path"),
                  bad, 0);
            for (int j = 0; j < BSR_W; j++) exp_upd[j] = pat(8 + j, c + 1);
            check("R9 update register", bsr_out, bsr_sel ? exp_upd : prev);
        end

        // TMS reset from Shift-DR with a floating instruction, R1 R6.
        load_ir(3'b000, irc);
        check("R2 EXTEST float", mem_hiz, 1);
        tick(1, 0); tick(0, 0); tick(0, 0);
        repeat (5) tick(1, 0);
        check("R1 R6 tms reset drops mem_hiz", mem_hiz, 0);
        tick(0, 0);
        scan_dr(32, {{(BSR_W-32){1'b0}}, ID_WORD}, 1'b0, 9, bad);
        check("R6 identity after tms reset", bad, 0);

        // trst_n reset, R1 R6.
        load_ir(3'b010, irc);
        check("R2 SAMPLE Z float", mem_hiz, 1);
        trst_n = 1'b0;
        tick(1, 0);
        trst_n = 1'b1;
        check("R1 R6 trst_n drops mem_hiz", mem_hiz, 0);
        tick(0, 0);
        check("R7 tdo_en idle", tdo_en, 0);
        scan_dr(32, {{(BSR_W-32){1'b0}}, ID_WORD}, 1'b0, 11, bad);
        check("R6 identity after trst_n", bad, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule